// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Wildcard Fields

This block sits beside a real-time clock's time counters. Each time the counters finish an update, a one-cycle strobe asks the block to compare the current seconds, minutes and hours bytes against three programmed alarm bytes. An alarm byte can be taken out of the comparison by writing ones into both of its two top bits. This makes the alarm fire once a day, once an hour, once a minute or on every update, depending on which bytes are wildcards.

The block keeps two sticky status flags. The alarm flag records a match. The update flag records that an update has finished. Each flag drives its own interrupt request through an enable. The update request is also held off while the transfer-inhibit input is high. A single combined request output is the OR of the two requests. A clear strobe, issued when software reads the status, resets both flags. The comparison does not depend on any enable, so it keeps running whenever the clock domain is alive, including when the system runs on backup power.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, both flags and all three interrupt outputs are 0.
- R2: On a clock edge with `upd_end` high, `alarm_flag` becomes 1 on that edge if every participating alarm byte equals its time byte. Each byte is compared as a whole, as 8 bits.
- R3: An alarm byte whose bits [7:6] are both 1 is a wildcard and always counts as matching. A byte with only one of those two bits set is compared normally.
- R4: With all three alarm bytes wildcards, every `upd_end` sets `alarm_flag`, whatever the time bytes hold.
- R5: If any participating byte differs from its time byte, an `upd_end` leaves `alarm_flag` at its previous value.
- R6: Without `upd_end`, `alarm_flag` never rises, even when the alarm bytes match the time bytes.
- R7: Every `upd_end` sets `update_flag` on that edge.
- R8: `update_irq` is 1 exactly when `update_flag` is 1, `update_ie` is 1 and `xfer_inhibit` is 0.
- R9: `alarm_irq` is `alarm_flag` AND `alarm_ie`. Both flags set regardless of the enables.
- R10: `flag_clr` clears both flags on the next edge. A flag whose set event arrives in the same cycle stays 1.
- R11: `irq` is 1 whenever `alarm_irq` or `update_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_end | input | 1 | One-cycle strobe at the end of a time update |
| tm_sec | input | 8 | Current seconds byte |
| tm_min | input | 8 | Current minutes byte |
| tm_hour | input | 8 | Current hours byte |
| al_sec | input | 8 | Seconds alarm byte (wildcard when [7:6]=11) |
| al_min | input | 8 | Minutes alarm byte (wildcard when [7:6]=11) |
| al_hour | input | 8 | Hours alarm byte (wildcard when [7:6]=11) |
| alarm_ie | input | 1 | Alarm interrupt enable |
| update_ie | input | 1 | Update-ended interrupt enable |
| xfer_inhibit | input | 1 | Transfer inhibit; blocks the update request |
| flag_clr | input | 1 | Status-read strobe that clears both flags |
| alarm_flag | output | 1 | Sticky alarm match flag |
| update_flag | output | 1 | Sticky update-ended flag |
| alarm_irq | output | 1 | Alarm interrupt request |
| update_irq | output | 1 | Update-ended interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong match decision shows at `alarm_flag` one edge after the `upd_end` strobe. Such a decision could come from a misread wildcard bit or from a byte dropped from the comparison. A wrong held value shows at the same edge: a flag that forgets it was set, or one that clears when a set arrives with the clear. The interrupt outputs depend only on the flags and the enables, so a gating error appears at once, in the cycle an enable or the inhibit changes. The checks therefore put the alarm bytes right next to the wildcard code (for example 0x80) and place set and clear in the same cycle. They then sample the flags one edge after each strobe.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned NUM_FIELDS = 3;
    localparam int unsigned WILD_BITS  = 2;

    // field slots inside the packed comparison vectors
    localparam int unsigned SLOT_SEC  = 0;
    localparam int unsigned SLOT_MIN  = 1;
    localparam int unsigned SLOT_HOUR = 2;

    typedef struct packed {
        logic alarm;
        logic update;
    } irq_vec_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int unsigned W         = rtc_alarm_pkg::FIELD_W,
    parameter int unsigned WILD_BITS = rtc_alarm_pkg::WILD_BITS
) (
    input  logic [W-1:0] time_i,
    input  logic [W-1:0] alarm_i,
    output logic         wild_o,
    output logic         hit_o
);
    localparam int unsigned TOP_LO = W - WILD_BITS;

    always_comb begin
        wild_o = &alarm_i[W-1:TOP_LO];
        hit_o  = wild_o || (time_i == alarm_i);
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter int unsigned W = rtc_alarm_pkg::FIELD_W,
    parameter int unsigned N = rtc_alarm_pkg::NUM_FIELDS
) (
    input  logic [N-1:0][W-1:0] time_i,
    input  logic [N-1:0][W-1:0] alarm_i,
    output logic                match_o,
    output logic                all_wild_o
);
    logic [N-1:0] hit_v;
    logic [N-1:0] wild_v;

    for (genvar g = 0; g < N; g++) begin : g_field
        alarm_field_cmp #(.W(W)) i_cmp (
            .time_i  (time_i[g]),
            .alarm_i (alarm_i[g]),
            .wild_o  (wild_v[g]),
            .hit_o   (hit_v[g])
        );
    end

    always_comb begin
        match_o    = &hit_v;
        all_wild_o = &wild_v;
    end
endmodule

// File: rtl/status_flag.sv
module status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // set has priority over a coincident clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int unsigned W = rtc_alarm_pkg::FIELD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_end,
    input  logic [W-1:0] tm_sec,
    input  logic [W-1:0] tm_min,
    input  logic [W-1:0] tm_hour,
    input  logic [W-1:0] al_sec,
    input  logic [W-1:0] al_min,
    input  logic [W-1:0] al_hour,
    input  logic         alarm_ie,
    input  logic         update_ie,
    input  logic         xfer_inhibit,
    input  logic         flag_clr,
    output logic         alarm_flag,
    output logic         update_flag,
    output logic         alarm_irq,
    output logic         update_irq,
    output logic         irq
);
    import rtc_alarm_pkg::*;

    localparam int unsigned N = NUM_FIELDS;

    logic [N-1:0][W-1:0] time_v;
    logic [N-1:0][W-1:0] alarm_v;
    logic                match;
    logic                all_wild;
    irq_vec_t            req;

    always_comb begin
        time_v[SLOT_SEC]   = tm_sec;
        time_v[SLOT_MIN]   = tm_min;
        time_v[SLOT_HOUR]  = tm_hour;
        alarm_v[SLOT_SEC]  = al_sec;
        alarm_v[SLOT_MIN]  = al_min;
        alarm_v[SLOT_HOUR] = al_hour;
    end

    alarm_match_unit #(.W(W), .N(N)) i_match (
        .time_i     (time_v),
        .alarm_i    (alarm_v),
        .match_o    (match),
        .all_wild_o (all_wild)
    );

    status_flag i_alarm_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (upd_end && match),
        .clr_i  (flag_clr),
        .flag_o (alarm_flag)
    );

    status_flag i_update_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (upd_end),
        .clr_i  (flag_clr),
        .flag_o (update_flag)
    );

    always_comb begin
        req.alarm  = alarm_flag && alarm_ie;
        req.update = update_flag && update_ie && !xfer_inhibit;
    end

    assign alarm_irq  = req.alarm;
    assign update_irq = req.update;
    assign irq        = |req;

    assert_all_wild_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_end && all_wild) |=> alarm_flag);
    assert_rise_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(upd_end));
    assert_update_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_end |=> update_flag);
    assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_inhibit |-> !update_irq);
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_end = 1'b0;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
    logic [7:0] al_sec = '0, al_min = '0, al_hour = '0;
    logic       alarm_ie = 1'b0, update_ie = 1'b0, xfer_inhibit = 1'b0, flag_clr = 1'b0;
    logic       alarm_flag, update_flag, alarm_irq, update_irq, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rtc_alarm_match i_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .upd_end(upd_end),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour),
        .alarm_ie(alarm_ie), .update_ie(update_ie), .xfer_inhibit(xfer_inhibit),
        .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .update_flag(update_flag),
        .alarm_irq(alarm_irq), .update_irq(update_irq), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one-cycle strobe driven between edges; returns at the negedge after the capturing edge
    task automatic pulse(input logic upd, input logic clr);
        @(negedge clk);
        upd_end = upd; flag_clr = clr;
        @(negedge clk);
        upd_end = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        tm_hour = h; tm_min = m; tm_sec = s;
    endtask

    task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        al_hour = h; al_min = m; al_sec = s;
    endtask

    task automatic t_reset;
        check(alarm_flag, 1'b0, "R1", "alarm_flag after reset");
        check(update_flag, 1'b0, "R1", "update_flag after reset");
        check(irq, 1'b0, "R1", "irq after reset");
        check(alarm_irq | update_irq, 1'b0, "R1", "requests after reset");
    endtask

    task automatic t_daily;
        set_time(8'h12, 8'h34, 8'h56);
        set_alarm(8'h12, 8'h34, 8'h56);
        alarm_ie = 1'b0; update_ie = 1'b0;
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b1, "R2", "full match sets flag");
        check(alarm_irq, 1'b0, "R9", "flag set but enable low");
        check(irq, 1'b0, "R11", "no enabled request");
        alarm_ie = 1'b1; #1;
        check(alarm_irq, 1'b1, "R9", "enable raises request");
        check(irq, 1'b1, "R11", "alarm request on irq");
        alarm_ie = 1'b0;
        pulse(1'b0, 1'b1);
        check(alarm_flag, 1'b0, "R10", "clear drops alarm flag");
        check(update_flag, 1'b0, "R10", "clear drops update flag");
    endtask

    task automatic t_mismatch;
        set_time(8'h12, 8'h34, 8'h56);
        set_alarm(8'h12, 8'h34, 8'h57);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b0, "R5", "seconds differ");
        set_alarm(8'h13, 8'h34, 8'h56);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b0, "R5", "hours differ");
        set_alarm(8'h12, 8'h35, 8'h56);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b0, "R5", "minutes differ");
        pulse(1'b0, 1'b1);
    endtask

    task automatic t_wildcards;
        set_time(8'h07, 8'h30, 8'h00);
        set_alarm(8'hC0, 8'h30, 8'h00);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b1, "R3", "hour wildcard C0 hourly");
        pulse(1'b0, 1'b1);
        set_alarm(8'hFF, 8'hC5, 8'h00);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b1, "R3", "hour+minute wildcard per minute");
        pulse(1'b0, 1'b1);
        set_alarm(8'h80, 8'h30, 8'h00);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b0, "R3", "80 is not a wildcard");
        set_alarm(8'h07, 8'h40, 8'h00);
        pulse(1'b1, 1'b0);
        check(alarm_flag, 1'b0, "R3", "40 is not a wildcard");
        pulse(1'b0, 1'b1);
    endtask

    task automatic t_every_update;
        set_alarm(8'hC0, 8'hC0, 8'hC0);
        for (int i = 0; i < 4; i++) begin
            set_time(8'(i * 5), 8'(i * 17), 8'(i * 29 + 3));
            pulse(1'b1, 1'b0);
            check(alarm_flag, 1'b1, "R4", "all wildcards fire");
            pulse(1'b0, 1'b1);
            check(alarm_flag, 1'b0, "R10", "cleared between updates");
        end
    endtask

    task automatic t_no_strobe;
        set_time(8'h23, 8'h59, 8'h59);
        set_alarm(8'h23, 8'h59, 8'h59);
        repeat (5) @(negedge clk);
        check(alarm_flag, 1'b0, "R6", "match without strobe");
        check(update_flag, 1'b0, "R7", "no strobe no update flag");
        set_alarm(8'hC0, 8'hC0, 8'hC0);
        repeat (3) @(negedge clk);
        check(alarm_flag, 1'b0, "R6", "wildcards without strobe");
    endtask

    task automatic t_update;
        set_alarm(8'h01, 8'h02, 8'h03);
        set_time(8'h00, 8'h00, 8'h00);
        update_ie = 1'b0; xfer_inhibit = 1'b0;
        pulse(1'b1, 1'b0);
        check(update_flag, 1'b1, "R7", "update flag set");
        check(update_irq, 1'b0, "R8", "enable low");
        update_ie = 1'b1; #1;
        check(update_irq, 1'b1, "R8", "enabled not inhibited");
        check(irq, 1'b1, "R11", "update request on irq");
        xfer_inhibit = 1'b1; #1;
        check(update_irq, 1'b0, "R8", "inhibit blocks request");
        check(irq, 1'b0, "R11", "irq low when blocked");
        xfer_inhibit = 1'b0; update_ie = 1'b0;
        pulse(1'b0, 1'b1);
        check(update_flag, 1'b0, "R10", "update flag cleared");
    endtask

    task automatic t_clear_race;
        set_time(8'h05, 8'h06, 8'h07);
        set_alarm(8'h05, 8'h06, 8'h07);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        check(alarm_flag, 1'b1, "R10", "set wins over clear alarm");
        check(update_flag, 1'b1, "R10", "set wins over clear update");
        set_alarm(8'h05, 8'h06, 8'h08);
        pulse(1'b1, 1'b1);
        check(alarm_flag, 1'b0, "R10", "clear with non-matching update");
        check(update_flag, 1'b1, "R10", "update set wins");
        pulse(1'b0, 1'b1);
        alarm_ie = 1'b1; update_ie = 1'b1; #1;
        check(irq, 1'b0, "R11", "no flags no irq");
        alarm_ie = 1'b0; update_ie = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_daily;
        t_mismatch;
        t_wildcards;
        t_every_update;
        t_no_strobe;
        t_update;
        t_clear_race;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule